// File: doc/BRIEF.md
# Turn-Synchronous Running-Sum Waveform Accumulator

This block turns a high-rate digitizer stream into a waveform locked to the beam revolution. It adds each group of `SUBS` consecutive samples into one bin value at the RF rate. A turn holds `BINS` such bins, and an external turn-marker pulse fixes the position of bin 0. For every bin the block keeps a sliding sum over the most recent N turns. It emits that sum as a stream of bin beats, and at the last bin of each turn it emits the integral of all bins. N is a runtime input and is limited to the range from 2 up to the history depth `HIST`.

Software can ask for a frozen copy of the waveform. A latch request arms a capture. The next complete turn that starts at bin 0 with a full N-turn window is copied into a snapshot store, together with its integral. The copy then stays fixed until the next request, so a slow bus master can read it one bin at a time. The block clears its window on three events: the history is restarted, N changes, or the turn marker goes missing. After any of these it reports sums as incomplete until N fresh turns have been gathered.

The design runs on a single clock at the sample rate, with a sample-enable input. The accumulator is `SAMP_W + log2(SUBS) + log2(HIST)` bits wide, so a sum over the deepest window cannot overflow.

Top module: `turn_sum_accumulator`

## Requirements
- R1: Each bin value is the sum of `SUBS` consecutive accepted samples. Bins are numbered 0 to `BINS-1` within a turn and appear in order on `sum_bin`.
- R2: The sample that arrives with `turn_mark` high is the first sample of bin 0. While the block is out of step, samples are ignored and produce no beat until a marked sample arrives.
- R3: Each beat's `sum_data` is the sum of that bin over the current turn and the N-1 turns before it, counting only turns since the last restart. `sum_full` is 1 exactly when that count reaches N turns.
- R4: The effective N is `n_turns` limited to the range [2, `HIST`]. A change of the effective N stops output until the next marked sample and restarts the history. A request outside the range that limits to the current N has no effect.
- R5: A marked sample that does not fall on the first sample of a turn raises `sync_err` for one cycle. That sample then becomes the first sample of bin 0 of a fresh history.
- R6: If the first sample of a turn arrives without a marker, the block drops out of step. Output stops until a marked sample arrives, and the history then restarts.
- R7: With the beat of bin `BINS-1`, `integ_vld` is high and `integ_data` carries the sum of all of that turn's `sum_data` values. `integ_full` carries that beat's `sum_full`.
- R8: A pulse on `latch_req` drops `snap_ready`. The next turn that starts at bin 0 with `sum_full` set is captured, and `snap_ready` then rises. `snap_integral` and the stored bins stay unchanged until the next pulse on `latch_req`.
- R9: `rd_data` returns the captured sum of bin `rd_addr` one clock after the address is presented.
- R10: A sum over `HIST` turns of full-scale samples is reported exactly, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_vld | input | 1 | Sample present this cycle |
| samp_data | input | SAMP_W | Unsigned digitizer sample |
| turn_mark | input | 1 | Marks the first sample of a turn (qualified by samp_vld) |
| n_turns | input | $clog2(HIST+1) | Requested window length in turns |
| latch_req | input | 1 | Arms a snapshot capture |
| rd_addr | input | $clog2(BINS) | Snapshot bin to read |
| sum_vld | output | 1 | Bin beat valid |
| sum_bin | output | $clog2(BINS) | Bin index of the beat |
| sum_data | output | ACC_W | N-turn sum for the bin |
| sum_full | output | 1 | Window holds N turns |
| integ_vld | output | 1 | Turn integral valid |
| integ_data | output | ACC_W+$clog2(BINS) | Sum of all bins of the turn |
| integ_full | output | 1 | Integral built from full windows |
| sync_err | output | 1 | Marker seen away from the turn start |
| snap_ready | output | 1 | Snapshot complete and held |
| snap_integral | output | ACC_W+$clog2(BINS) | Integral of the captured turn |
| rd_data | output | ACC_W | Captured bin sum, one cycle after rd_addr |

## Verification
A bin beat appears on `sum_vld` in the cycle after the clock edge that follows the edge taking the bin's last sample. `integ_vld` comes with the beat of the last bin. `sync_err` shows in the cycle after the edge that took the misplaced marker. `snap_ready` rises one cycle after the last captured beat, and `rd_data` follows `rd_addr` by one edge. The driver computes every expected beat and integral from its own per-turn record and queues them in order. A monitor compares them on the falling edge whenever a beat or an integral is flagged, so a beat that is early, late, missing or extra is reported without the check depending on exact cycle counts. Snapshot reads and status flags are checked at fixed points one edge after their stimulus, once the stream is idle.

// File: rtl/tsa_pkg.sv
`timescale 1ns/1ps
// Shared types for the turn-synchronous accumulator.
package tsa_pkg;
    // Snapshot capture phases.
    typedef enum logic [1:0] {
        CAP_HOLD  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_COPY  = 2'd2
    } cap_state_t;
endpackage

// File: rtl/tsa_bin_former.sv
`timescale 1ns/1ps
// Bin former: tracks turn phase from the marker, sums SUBS samples per bin,
// limits the requested window length and flags resynchronisation events.
// Assumes samp_data is unsigned and turn_mark is only meaningful with samp_vld.
module tsa_bin_former #(
    parameter int SAMP_W = 12,
    parameter int SUBS   = 4,
    parameter int BINS   = 588,
    parameter int HIST   = 4,
    localparam int NW    = $clog2(HIST + 1),
    localparam int BW    = $clog2(BINS),
    localparam int SBW   = $clog2(SUBS),
    localparam int BV_W  = SAMP_W + SBW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_vld,
    input  logic [SAMP_W-1:0] samp_data,
    input  logic              turn_mark,
    input  logic [NW-1:0]     n_req,
    output logic              bin_stb,
    output logic [BW-1:0]     bin_idx,
    output logic [BV_W-1:0]   bin_val,
    output logic              restart,
    output logic              sync_err,
    output logic [NW-1:0]     n_act
);
    logic              in_sync;
    logic [BW-1:0]     bin_q;
    logic [SBW-1:0]    sub_q;
    logic [BV_W-1:0]   part_q;
    logic [NW-1:0]     n_lim;
    logic              at_start;
    logic              fresh;
    logic [BW-1:0]     use_bin;
    logic [SBW-1:0]    use_sub;
    logic [BV_W-1:0]   sum_now;

    // Limit the requested window to the supported range.
    always_comb begin
        if (n_req < NW'(2))          n_lim = NW'(2);
        else if (n_req > NW'(HIST))  n_lim = NW'(HIST);
        else                         n_lim = n_req;
    end

    // Position of the current sample within the turn and its partial sum.
    always_comb begin
        at_start = (bin_q == '0) && (sub_q == '0);
        fresh    = in_sync ? (turn_mark && !at_start) : turn_mark;
        use_bin  = fresh ? '0 : bin_q;
        use_sub  = fresh ? '0 : sub_q;
        sum_now  = ((use_sub == '0) ? '0 : part_q) + BV_W'(samp_data);
    end

    // Phase tracking, bin completion and restart signalling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync  <= 1'b0;
            bin_q    <= '0;
            sub_q    <= '0;
            part_q   <= '0;
            bin_stb  <= 1'b0;
            bin_idx  <= '0;
            bin_val  <= '0;
            restart  <= 1'b0;
            sync_err <= 1'b0;
            n_act    <= NW'(2);
        end else begin
            bin_stb  <= 1'b0;
            restart  <= 1'b0;
            sync_err <= 1'b0;
            if (n_lim != n_act) begin
                n_act   <= n_lim;
                in_sync <= 1'b0;
                restart <= 1'b1;
            end else if (samp_vld) begin
                if (in_sync && at_start && !turn_mark) begin
                    in_sync <= 1'b0;
                    restart <= 1'b1;
                end else if (in_sync || turn_mark) begin
                    if (fresh) begin
                        in_sync <= 1'b1;
                        restart <= 1'b1;
                        sync_err <= in_sync;
                    end
                    if (use_sub == SBW'(SUBS - 1)) begin
                        bin_stb <= 1'b1;
                        bin_idx <= use_bin;
                        bin_val <= sum_now;
                        sub_q   <= '0;
                        part_q  <= '0;
                        bin_q   <= (use_bin == BW'(BINS - 1)) ? '0 : use_bin + 1'b1;
                    end else begin
                        sub_q   <= use_sub + 1'b1;
                        part_q  <= sum_now;
                        bin_q   <= use_bin;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tsa_window.sv
`timescale 1ns/1ps
// Sliding window: per-bin running sum over the last n_act turns, kept by
// adding the new bin and subtracting the one stored n_act turns earlier in a
// circular history. Memories are never cleared; a turn count since restart
// masks stale entries instead. Also forms the per-turn integral.
// Assumes restart and bin_stb never arrive in the same cycle.
module tsa_window #(
    parameter int BV_W  = 14,
    parameter int BINS  = 588,
    parameter int HIST  = 4,
    parameter int ACC_W = 16,
    parameter int INT_W = 26,
    localparam int NW   = $clog2(HIST + 1),
    localparam int BW   = $clog2(BINS),
    localparam int SLW  = $clog2(HIST),
    localparam int XW   = SLW + 2,
    localparam int HA_W = $clog2(HIST * BINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_stb,
    input  logic [BW-1:0]     bin_idx,
    input  logic [BV_W-1:0]   bin_val,
    input  logic              restart,
    input  logic [NW-1:0]     n_act,
    output logic              sum_vld,
    output logic [BW-1:0]     sum_bin,
    output logic [ACC_W-1:0]  sum_data,
    output logic              sum_full,
    output logic              integ_vld,
    output logic [INT_W-1:0]  integ_data,
    output logic              integ_full
);
    logic [ACC_W-1:0] acc_mem  [BINS];
    logic [BV_W-1:0]  hist_mem [HIST*BINS];

    logic [NW-1:0]    filled;
    logic [SLW-1:0]   slot;
    logic [INT_W-1:0] run;
    logic [XW-1:0]    os_raw;
    logic [SLW-1:0]   old_slot;
    logic [HA_W-1:0]  wr_addr;
    logic [HA_W-1:0]  rd_addr;
    logic [ACC_W-1:0] acc_base;
    logic [ACC_W-1:0] old_val;
    logic [ACC_W-1:0] new_acc;
    logic             full_now;
    logic             last_bin;

    // Locate the bin that leaves the window and form the new sum.
    always_comb begin
        os_raw   = XW'(slot) + XW'(HIST) - XW'(n_act);
        old_slot = SLW'((os_raw >= XW'(HIST)) ? os_raw - XW'(HIST) : os_raw);
        wr_addr  = HA_W'(slot) * HA_W'(BINS) + HA_W'(bin_idx);
        rd_addr  = HA_W'(old_slot) * HA_W'(BINS) + HA_W'(bin_idx);
        acc_base = (filled == '0) ? '0 : acc_mem[bin_idx];
        old_val  = (filled >= n_act) ? ACC_W'(hist_mem[rd_addr]) : '0;
        new_acc  = acc_base + ACC_W'(bin_val) - old_val;
        full_now = ((NW+1)'(filled) + (NW+1)'(1)) >= (NW+1)'(n_act);
        last_bin = (bin_idx == BW'(BINS - 1));
    end

    // Storage writes for the running sums and the turn history.
    always_ff @(posedge clk) begin
        if (bin_stb && !restart) begin
            acc_mem[bin_idx]  <= new_acc;
            hist_mem[wr_addr] <= bin_val;
        end
    end

    // Turn bookkeeping, output beats and the per-turn integral.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled     <= '0;
            slot       <= '0;
            run        <= '0;
            sum_vld    <= 1'b0;
            sum_bin    <= '0;
            sum_data   <= '0;
            sum_full   <= 1'b0;
            integ_vld  <= 1'b0;
            integ_data <= '0;
            integ_full <= 1'b0;
        end else begin
            sum_vld   <= 1'b0;
            integ_vld <= 1'b0;
            if (restart) begin
                filled <= '0;
                slot   <= '0;
                run    <= '0;
            end else if (bin_stb) begin
                sum_vld  <= 1'b1;
                sum_bin  <= bin_idx;
                sum_data <= new_acc;
                sum_full <= full_now;
                if (last_bin) begin
                    integ_vld  <= 1'b1;
                    integ_data <= run + INT_W'(new_acc);
                    integ_full <= full_now;
                    run        <= '0;
                    filled     <= (filled == NW'(HIST)) ? filled : filled + 1'b1;
                    slot       <= (slot == SLW'(HIST - 1)) ? '0 : slot + 1'b1;
                end else begin
                    run <= run + INT_W'(new_acc);
                end
            end
        end
    end
endmodule

// File: rtl/tsa_snapshot.sv
`timescale 1ns/1ps
// Snapshot: on a latch request, captures the next complete full-window turn
// from the beat stream into a bin store plus its integral, then holds them
// for slow readout. The restart input is delayed one cycle so it lines up
// with beats that left the window stage before the restart.
module tsa_snapshot
    import tsa_pkg::*;
#(
    parameter int BINS  = 588,
    parameter int ACC_W = 16,
    parameter int INT_W = 26,
    localparam int BW   = $clog2(BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sum_vld,
    input  logic [BW-1:0]    sum_bin,
    input  logic [ACC_W-1:0] sum_data,
    input  logic             sum_full,
    input  logic             integ_vld,
    input  logic [INT_W-1:0] integ_data,
    input  logic             restart_in,
    input  logic             latch_req,
    input  logic [BW-1:0]    rd_addr,
    output logic             snap_ready,
    output logic [INT_W-1:0] snap_integral,
    output logic [ACC_W-1:0] rd_data
);
    logic [ACC_W-1:0] snap_mem [BINS];
    cap_state_t       state;
    logic             restart_d;
    logic             take_beat;

    // A beat is stored when it opens or continues a capture.
    always_comb begin
        take_beat = !latch_req && !restart_d && sum_vld &&
                    (((state == CAP_ARMED) && (sum_bin == '0) && sum_full) ||
                     (state == CAP_COPY));
    end

    // Capture sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= CAP_HOLD;
            restart_d     <= 1'b0;
            snap_ready    <= 1'b0;
            snap_integral <= '0;
        end else begin
            restart_d <= restart_in;
            if (latch_req) begin
                state      <= CAP_ARMED;
                snap_ready <= 1'b0;
            end else if (restart_d) begin
                if (state == CAP_COPY) state <= CAP_ARMED;
            end else if (sum_vld) begin
                if (state == CAP_ARMED && sum_bin == '0 && sum_full) begin
                    state <= CAP_COPY;
                end else if (state == CAP_COPY && integ_vld) begin
                    state         <= CAP_HOLD;
                    snap_ready    <= 1'b1;
                    snap_integral <= integ_data;
                end
            end
        end
    end

    // Bin store write and registered readout.
    always_ff @(posedge clk) begin
        if (take_beat) snap_mem[sum_bin] <= sum_data;
        rd_data <= (rd_addr < BW'(BINS)) ? snap_mem[rd_addr] : '0;
    end
endmodule

// File: rtl/turn_sum_accumulator.sv
`timescale 1ns/1ps
// Top: turn-synchronous N-turn running-sum waveform accumulator.
// Chain: bin former -> sliding window -> snapshot store.
// Assumes n_turns changes only while no bin is in flight.
module turn_sum_accumulator #(
    parameter int SAMP_W = 12,
    parameter int SUBS   = 4,
    parameter int BINS   = 588,
    parameter int HIST   = 4,
    localparam int NW    = $clog2(HIST + 1),
    localparam int BW    = $clog2(BINS),
    localparam int BV_W  = SAMP_W + $clog2(SUBS),
    localparam int ACC_W = BV_W + $clog2(HIST),
    localparam int INT_W = ACC_W + $clog2(BINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_vld,
    input  logic [SAMP_W-1:0] samp_data,
    input  logic              turn_mark,
    input  logic [NW-1:0]     n_turns,
    input  logic              latch_req,
    input  logic [BW-1:0]     rd_addr,
    output logic              sum_vld,
    output logic [BW-1:0]     sum_bin,
    output logic [ACC_W-1:0]  sum_data,
    output logic              sum_full,
    output logic              integ_vld,
    output logic [INT_W-1:0]  integ_data,
    output logic              integ_full,
    output logic              sync_err,
    output logic              snap_ready,
    output logic [INT_W-1:0]  snap_integral,
    output logic [ACC_W-1:0]  rd_data
);
    logic            bin_stb;
    logic [BW-1:0]   bin_idx;
    logic [BV_W-1:0] bin_val;
    logic            restart;
    logic [NW-1:0]   n_act;

    tsa_bin_former #(
        .SAMP_W(SAMP_W), .SUBS(SUBS), .BINS(BINS), .HIST(HIST)
    ) u_former (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_data(samp_data),
        .turn_mark(turn_mark), .n_req(n_turns), .bin_stb(bin_stb),
        .bin_idx(bin_idx), .bin_val(bin_val), .restart(restart),
        .sync_err(sync_err), .n_act(n_act)
    );

    tsa_window #(
        .BV_W(BV_W), .BINS(BINS), .HIST(HIST), .ACC_W(ACC_W), .INT_W(INT_W)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .bin_stb(bin_stb), .bin_idx(bin_idx),
        .bin_val(bin_val), .restart(restart), .n_act(n_act),
        .sum_vld(sum_vld), .sum_bin(sum_bin), .sum_data(sum_data),
        .sum_full(sum_full), .integ_vld(integ_vld), .integ_data(integ_data),
        .integ_full(integ_full)
    );

    tsa_snapshot #(
        .BINS(BINS), .ACC_W(ACC_W), .INT_W(INT_W)
    ) u_snap (
        .clk(clk), .rst_n(rst_n), .sum_vld(sum_vld), .sum_bin(sum_bin),
        .sum_data(sum_data), .sum_full(sum_full), .integ_vld(integ_vld),
        .integ_data(integ_data), .restart_in(restart), .latch_req(latch_req),
        .rd_addr(rd_addr), .snap_ready(snap_ready),
        .snap_integral(snap_integral), .rd_data(rd_data)
    );
endmodule

// File: rtl/tsa_checker.sv
`timescale 1ns/1ps
// Protocol checker for turn_sum_accumulator, attached by bind below.
module tsa_checker #(
    parameter int SAMP_W = 12,
    parameter int SUBS   = 4,
    parameter int BINS   = 588,
    parameter int HIST   = 4,
    localparam int BW    = $clog2(BINS),
    localparam int ACC_W = SAMP_W + $clog2(SUBS) + $clog2(HIST),
    localparam int INT_W = ACC_W + $clog2(BINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_vld,
    input logic             turn_mark,
    input logic             latch_req,
    input logic             sync_err,
    input logic             sum_vld,
    input logic [BW-1:0]    sum_bin,
    input logic [ACC_W-1:0] sum_data,
    input logic             integ_vld,
    input logic             snap_ready,
    input logic [INT_W-1:0] snap_integral
);
    localparam logic [ACC_W-1:0] MAX_SUM =
        ACC_W'(HIST * SUBS * ((1 << SAMP_W) - 1));

    a_r1_bin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |-> (sum_bin < BW'(BINS)));

    a_r5_err_follows_mark: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> $past(samp_vld && turn_mark));

    a_r7_integ_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        integ_vld |-> (sum_vld && sum_bin == BW'(BINS - 1)));

    a_r8_snap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_ready && !latch_req) |=> (snap_ready && $stable(snap_integral)));

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sum_vld |-> (sum_data <= MAX_SUM));
endmodule

bind turn_sum_accumulator tsa_checker #(
    .SAMP_W(SAMP_W), .SUBS(SUBS), .BINS(BINS), .HIST(HIST)
) u_tsa_checker (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .turn_mark(turn_mark),
    .latch_req(latch_req), .sync_err(sync_err), .sum_vld(sum_vld),
    .sum_bin(sum_bin), .sum_data(sum_data), .integ_vld(integ_vld),
    .snap_ready(snap_ready), .snap_integral(snap_integral)
);

// File: tb/test_turn_sum_accumulator.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models expected beats and integrals into
// queues; a falling-edge monitor pops and compares them.
module test_turn_sum_accumulator;
    localparam int SW_T   = 8;
    localparam int SUBS_T = 4;
    localparam int BINS_T = 6;
    localparam int HIST_T = 4;
    localparam int NW_T   = $clog2(HIST_T + 1);
    localparam int BW_T   = $clog2(BINS_T);
    localparam int ACC_T  = SW_T + $clog2(SUBS_T) + $clog2(HIST_T);
    localparam int INT_T  = ACC_T + $clog2(BINS_T);
    localparam int SPT    = BINS_T * SUBS_T;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              samp_vld = 1'b0;
    logic [SW_T-1:0]   samp_data = '0;
    logic              turn_mark = 1'b0;
    logic [NW_T-1:0]   n_turns = NW_T'(2);
    logic              latch_req = 1'b0;
    logic [BW_T-1:0]   rd_addr = '0;
    logic              sum_vld;
    logic [BW_T-1:0]   sum_bin;
    logic [ACC_T-1:0]  sum_data;
    logic              sum_full;
    logic              integ_vld;
    logic [INT_T-1:0]  integ_data;
    logic              integ_full;
    logic              sync_err;
    logic              snap_ready;
    logic [INT_T-1:0]  snap_integral;
    logic [ACC_T-1:0]  rd_data;

    turn_sum_accumulator #(
        .SAMP_W(SW_T), .SUBS(SUBS_T), .BINS(BINS_T), .HIST(HIST_T)
    ) i_turn_sum_accumulator (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_data(samp_data),
        .turn_mark(turn_mark), .n_turns(n_turns), .latch_req(latch_req),
        .rd_addr(rd_addr), .sum_vld(sum_vld), .sum_bin(sum_bin),
        .sum_data(sum_data), .sum_full(sum_full), .integ_vld(integ_vld),
        .integ_data(integ_data), .integ_full(integ_full), .sync_err(sync_err),
        .snap_ready(snap_ready), .snap_integral(snap_integral), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    typedef struct { int bin; int data; int full; } beat_t;
    beat_t bq[$];
    int    iq_d[$];
    int    iq_f[$];

    int    n_chk = 0;
    int    n_err = 0;
    int    err_seen = 0;
    int    exp_err = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Reference model state.
    int m_sync = 0, m_bin = 0, m_sub = 0, m_part = 0, m_t = 0, m_n = 2, m_run = 0;
    int tv[256][BINS_T];
    int s_state = 0, s_ready = 0, s_int = 0;
    int s_vals[BINS_T];

    task automatic chk(input string req, input string what, input longint act,
                       input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_restart();
        m_t = 0; m_run = 0; m_bin = 0; m_sub = 0; m_part = 0;
        if (s_state == 2) s_state = 1;
    endfunction

    function automatic void model_take(input int d);
        int v, e, full;
        beat_t b;
        m_part += d;
        if (m_sub == SUBS_T - 1) begin
            v = m_part;
            tv[m_t][m_bin] = v;
            e = 0;
            for (int k = 0; k < m_n; k++) if (m_t - k >= 0) e += tv[m_t-k][m_bin];
            full = (m_t >= m_n - 1) ? 1 : 0;
            b.bin = m_bin; b.data = e; b.full = full;
            bq.push_back(b);
            if (s_state == 1 && m_bin == 0 && full == 1) s_state = 2;
            if (s_state == 2) s_vals[m_bin] = e;
            m_run += e;
            if (m_bin == BINS_T - 1) begin
                iq_d.push_back(m_run);
                iq_f.push_back(full);
                if (s_state == 2) begin s_int = m_run; s_ready = 1; s_state = 0; end
                m_run = 0;
                if (m_t < 255) m_t++;
                m_bin = 0;
            end else begin
                m_bin++;
            end
            m_sub = 0; m_part = 0;
        end else begin
            m_sub++;
        end
    endfunction

    function automatic void model_step(input int d, input bit mk);
        bit at_start = (m_bin == 0 && m_sub == 0);
        if (m_sync == 0) begin
            if (mk) begin m_sync = 1; model_restart(); model_take(d); end
        end else if (at_start && !mk) begin
            m_sync = 0; model_restart();
        end else if (!at_start && mk) begin
            exp_err++; model_restart(); model_take(d);
        end else begin
            model_take(d);
        end
    endfunction

    task automatic sample(input int d, input bit mk);
        samp_vld = 1'b1; samp_data = SW_T'(d); turn_mark = mk;
        model_step(d, mk);
        @(negedge clk);
        samp_vld = 1'b0; turn_mark = 1'b0;
    endtask

    task automatic run_turns(input int count, input int seed, input bit mark);
        for (int t = 0; t < count; t++)
            for (int i = 0; i < SPT; i++)
                sample((seed * 37 + t * 53 + i * 11 + 5) % 256, mark && (i == 0));
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic set_n(input int v);
        int c = (v < 2) ? 2 : ((v > HIST_T) ? HIST_T : v);
        n_turns = NW_T'(v);
        if (c != m_n) begin m_n = c; m_sync = 0; model_restart(); end
        idle(3);
    endtask

    task automatic do_latch();
        latch_req = 1'b1; s_state = 1; s_ready = 0;
        @(negedge clk);
        latch_req = 1'b0;
        chk("R8", "snap_ready after latch request", snap_ready, 0);
    endtask

    task automatic check_snap();
        chk("R8", "snap_ready after captured turn", snap_ready, s_ready);
        chk("R8", "snapshot integral", snap_integral, s_int);
        for (int b = 0; b < BINS_T; b++) begin
            rd_addr = BW_T'(b);
            @(negedge clk);
            chk("R9", $sformatf("snapshot bin %0d", b), rd_data, s_vals[b]);
        end
    endtask

    // Monitor: compares beats and integrals against the model queues.
    always @(negedge clk) begin
        beat_t b;
        if (rst_n && !done) begin
            if (sync_err) err_seen++;
            if (sum_vld) begin
                if (bq.size() == 0) begin
                    chk(tag, "unexpected beat, bin", sum_bin, -1);
                end else begin
                    b = bq.pop_front();
                    chk(tag, "R1 bin index", sum_bin, b.bin);
                    chk(tag, "R3 bin sum", sum_data, b.data);
                    chk(tag, "R3 window full", sum_full, b.full);
                end
            end
            if (integ_vld) begin
                if (iq_d.size() == 0) begin
                    chk("R7", "unexpected integral", integ_data, -1);
                end else begin
                    chk("R7", "turn integral", integ_data, iq_d.pop_front());
                    chk("R7", "integral full flag", integ_full, iq_f.pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1", "sum_vld after reset", sum_vld, 0);
        chk("R5", "sync_err after reset", sync_err, 0);
        chk("R8", "snap_ready after reset", snap_ready, 0);

        // R2: unmarked samples before the first marker are ignored.
        tag = "R2";
        for (int i = 0; i < 7; i++) sample(100 + i, 1'b0);
        idle(4);
        chk("R2", "beats before first marker", bq.size(), 0);

        // R3: window of three turns over varied data.
        tag = "R3";
        set_n(3);
        run_turns(6, 1, 1'b1);
        idle(4);

        // R8 / R9: capture, read, then confirm the copy stays put.
        tag = "R8";
        do_latch();
        run_turns(2, 7, 1'b1);
        idle(4);
        check_snap();
        run_turns(2, 9, 1'b1);
        idle(4);
        check_snap();

        // R10: deepest window of full-scale samples.
        tag = "R10";
        set_n(HIST_T);
        for (int t = 0; t < HIST_T + 1; t++)
            for (int i = 0; i < SPT; i++) sample(255, i == 0);
        idle(4);

        // R4: over-range request that limits to the current N, then a real change.
        tag = "R4";
        set_n(HIST_T + 3);
        run_turns(2, 3, 1'b1);
        idle(4);
        set_n(0);
        for (int i = 0; i < 5; i++) sample(17, 1'b0);
        run_turns(3, 4, 1'b1);
        idle(4);

        // R5: marker arriving mid-turn restarts at bin 0.
        tag = "R5";
        for (int i = 0; i < 9; i++) sample(30 + i, i == 0);
        sample(200, 1'b1);
        for (int i = 1; i < SPT; i++) sample(40 + i, 1'b0);
        run_turns(3, 5, 1'b1);
        idle(4);

        // R6: turn start without marker drops sync until the next marker.
        tag = "R6";
        run_turns(1, 6, 1'b0);
        run_turns(3, 8, 1'b1);
        idle(4);

        // R8: restart during capture defers it to a later full turn.
        tag = "R8";
        do_latch();
        for (int i = 0; i < 10; i++) sample(60 + i, i == 0);
        sample(61, 1'b1);
        for (int i = 1; i < SPT; i++) sample(70 + i, 1'b0);
        run_turns(3, 11, 1'b1);
        idle(4);
        check_snap();

        idle(6);
        done = 1'b1;
        chk("R5", "sync error pulses", err_seen, exp_err);
        chk("R3", "beats left unmatched", bq.size(), 0);
        chk("R7", "integrals left unmatched", iq_d.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule